// File: doc/BRIEF.md
# Dual-Structure Serial CRC-5 Engine

This block computes a 5-bit cyclic redundancy remainder over a message that arrives one bit per cycle, most significant bit first. The generator polynomial is x^5 + x^2 + x + 1. Two shift-register structures sit side by side, and a mode input picks one of them for each message. The direct structure folds every incoming bit into the feedback path, so the remainder is ready once the last message bit has been taken. The division structure works like long division on the message followed by five zero bits. The block appends those zeros itself, one per cycle, after the last message bit.

Both structures return the same remainder, M(x)·x^5 mod G(x). They differ only in when that remainder appears: one cycle after the last bit in direct mode, and six cycles after it in division mode. A synchronous clear brings the register back to all zeros and restarts the sequence. The done flag then stays high, with the remainder held, until the next clear.

Top module: `crc5_dual_lfsr`

## Requirements
- R1: After reset, `crc_out` is 00000 and `done` is 0.
- R2: With `mode_aug`=0, the last bit is the one taken with `bit_last`=1. `done` rises in the cycle after that bit is taken, and `crc_out` then holds M(x)·x^5 mod (x^5+x^2+x+1), where the first bit sent is the highest coefficient of M(x).
- R3: With `mode_aug`=1, the block shifts five zero bits by itself after the last message bit. `done` stays 0 for five cycles and rises six cycles after the last bit was taken. `crc_out` then holds the same remainder as in R2.
- R4: For the stream 1,0,0,1,0,0,1,1, both modes give `crc_out` = 01010.
- R5: A cycle with `clr`=1 sets `crc_out` to 00000 and `done` to 0 at the next edge, and it takes priority over a valid bit in the same cycle.
- R6: A cycle with `bit_vld`=0 outside the zero-append phase leaves `crc_out` unchanged, so idle gaps within a message do not alter the result.
- R7: While the five zeros are being appended, `bit_vld`, `bit_in` and `bit_last` are ignored.
- R8: Once `done` is 1, both `done` and `crc_out` hold and further valid bits are ignored until `clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the register and sequence |
| mode_aug | input | 1 | 0 = direct structure, 1 = division structure with appended zeros |
| bit_vld | input | 1 | `bit_in` carries a message bit this cycle |
| bit_in | input | 1 | Serial message bit, MSB first |
| bit_last | input | 1 | Marks the final message bit (qualified by `bit_vld`) |
| crc_out | output | 5 | Remainder register |
| done | output | 1 | Remainder is final |

## Verification
The bench compares every message in both modes against a long-division model of its own. An engine that shifts four or six zeros in division mode, or raises done one cycle early, returns a wrong remainder or fails the cycle-exact done check. During the zero-append phase, ones are forced onto the inputs; a design that lets them through produces a corrupted remainder. The bench also inserts idle gaps, sends bits after done, and raises clear together with a valid bit. A design that shifts on idle cycles, keeps accepting bits after done, or lets a bit beat the clear ends up with a wrong or non-zero register.

// File: rtl/crc5_pkg.sv
package crc5_pkg;
  localparam int CRC_W = 5;
  // low coefficients of x^5 + x^2 + x + 1 (x^5 implicit)
  localparam logic [CRC_W-1:0] GEN_TAPS = 5'b00111;
  localparam int FCNT_W = $clog2(CRC_W + 1);

  typedef enum logic [1:0] {
    ST_MSG   = 2'd0,
    ST_FLUSH = 2'd1,
    ST_DONE  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/crc5_dir_step.sv
module crc5_dir_step #(
  parameter int W = 5,
  parameter logic [W-1:0] TAPS = '0
) (
  input  logic [W-1:0] crc_q,
  input  logic         din,
  output logic [W-1:0] crc_d
);
  logic fb;
  assign fb = crc_q[W-1] ^ din;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign crc_d[i] = TAPS[i] & fb;
    end else begin : g_up
      assign crc_d[i] = crc_q[i-1] ^ (TAPS[i] & fb);
    end
  end
endmodule

// File: rtl/crc5_div_step.sv
module crc5_div_step #(
  parameter int W = 5,
  parameter logic [W-1:0] TAPS = '0
) (
  input  logic [W-1:0] crc_q,
  input  logic         din,
  output logic [W-1:0] crc_d
);
  logic [W-1:0] shifted;
  assign shifted = {crc_q[W-2:0], din};

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign crc_d[i] = shifted[i] ^ (TAPS[i] & crc_q[W-1]);
  end
endmodule

// File: rtl/crc5_seq.sv
module crc5_seq
  import crc5_pkg::*;
#(
  parameter int W = CRC_W,
  parameter int CW = FCNT_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic mode_aug,
  input  logic bit_vld,
  input  logic bit_last,
  output logic take_bit,
  output logic flushing,
  output logic shift_en,
  output logic done
);
  seq_state_t      state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            cnt_en;

  assign take_bit = (state_q == ST_MSG) && bit_vld;
  assign flushing = (state_q == ST_FLUSH);
  assign shift_en = take_bit || flushing;
  assign done     = (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (clr) begin
      state_d = ST_MSG;
      cnt_d   = '0;
      cnt_en  = 1'b1;
    end else begin
      case (state_q)
        ST_MSG: begin
          if (take_bit && bit_last) begin
            if (mode_aug) begin
              state_d = ST_FLUSH;
              cnt_d   = CW'(W);
              cnt_en  = 1'b1;
            end else begin
              state_d = ST_DONE;
            end
          end
        end
        ST_FLUSH: begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
          if (cnt_q == CW'(1)) state_d = ST_DONE;
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_MSG;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/crc5_dual_lfsr.sv
module crc5_dual_lfsr
  import crc5_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             mode_aug,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic             bit_last,
  output logic [CRC_W-1:0] crc_out,
  output logic             done
);
  logic             take_bit, flushing, shift_en;
  logic             step_din;
  logic [CRC_W-1:0] crc_q, crc_d, dir_nxt, div_nxt;

  crc5_seq #(.W(CRC_W), .CW(FCNT_W)) i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .mode_aug (mode_aug),
    .bit_vld  (bit_vld),
    .bit_last (bit_last),
    .take_bit (take_bit),
    .flushing (flushing),
    .shift_en (shift_en),
    .done     (done)
  );

  // appended zeros replace the input during the flush phase
  assign step_din = flushing ? 1'b0 : bit_in;

  crc5_dir_step #(.W(CRC_W), .TAPS(GEN_TAPS)) i_dir (
    .crc_q (crc_q),
    .din   (step_din),
    .crc_d (dir_nxt)
  );

  crc5_div_step #(.W(CRC_W), .TAPS(GEN_TAPS)) i_div (
    .crc_q (crc_q),
    .din   (step_din),
    .crc_d (div_nxt)
  );

  always_comb begin
    if (clr)                       crc_d = '0;
    else if (flushing || mode_aug) crc_d = div_nxt;
    else                           crc_d = dir_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                crc_q <= '0;
    else if (clr || shift_en)  crc_q <= crc_d;
  end

  assign crc_out = crc_q;
endmodule

// File: rtl/crc5_dual_lfsr_chk.sv
module crc5_dual_lfsr_chk
  import crc5_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             mode_aug,
  input logic             bit_vld,
  input logic             bit_last,
  input logic             take_bit,
  input logic             flushing,
  input logic [CRC_W-1:0] crc_out,
  input logic             done
);
  logic [3:0] gap_q;
  logic       mode_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      mode_l <= 1'b0;
    end else if (clr) begin
      gap_q  <= '0;
    end else if (take_bit && bit_last) begin
      gap_q  <= '0;
      mode_l <= mode_aug;
    end else if (gap_q != 4'hF) begin
      gap_q  <= gap_q + 4'd1;
    end
  end

  // R5: clear wins and empties the register
  a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc_out == '0 && !done));

  // R2: direct mode finishes right after the last bit
  a_r2_direct_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && take_bit && bit_last && !mode_aug) |=> done);

  // R3: done rises exactly CRC_W cycles later in division mode
  a_r3_flush_len: assert property (@(posedge clk) disable iff (!rst_n || clr)
    $rose(done) |-> (int'(gap_q) == (mode_l ? CRC_W : 0)));

  // R6: idle cycles do not move the register
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !bit_vld && !flushing) |=> $stable(crc_out));

  // R8: finished result holds until clear
  a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> (done && $stable(crc_out)));

  // R7: no message bit is taken during the zero-append phase
  a_r7_flush_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    flushing |-> !take_bit);
endmodule

bind crc5_dual_lfsr crc5_dual_lfsr_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr      (clr),
  .mode_aug (mode_aug),
  .bit_vld  (bit_vld),
  .bit_last (bit_last),
  .take_bit (take_bit),
  .flushing (flushing),
  .crc_out  (crc_out),
  .done     (done)
);

// File: tb/test_crc5_dual_lfsr.sv
module test_crc5_dual_lfsr;
  logic       clk = 1'b0;
  logic       rst_n, clr, mode_aug, bit_vld, bit_in, bit_last;
  logic [4:0] crc_out;
  logic       done;
  int         n_checks = 0;
  int         n_errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  crc5_dual_lfsr i_crc5_dual_lfsr (
    .clk(clk), .rst_n(rst_n), .clr(clr), .mode_aug(mode_aug),
    .bit_vld(bit_vld), .bit_in(bit_in), .bit_last(bit_last),
    .crc_out(crc_out), .done(done)
  );

  localparam int NV = 8;
  localparam logic [15:0] V_MSG [NV] = '{16'h0093, 16'h0001, 16'h0010, 16'hFFFF,
                                         16'hA5C3, 16'h0801, 16'h0003, 16'h007F};
  localparam int          V_LEN [NV] = '{8, 1, 5, 16, 16, 12, 3, 7};

  // long division of M(x)*x^5 by x^5+x^2+x+1
  function automatic logic [4:0] ref_rem(input logic [15:0] m, input int n);
    logic [31:0] a;
    a = 32'(m) << 5;
    for (int i = n + 4; i >= 5; i--)
      if (a[i]) a = a ^ (32'h27 << (i - 5));
    return a[4:0];
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  // send a message, optionally with idle gaps and flush-phase pokes
  task automatic send_msg(input logic aug, input logic [15:0] m, input int n,
                          input int gap, input logic poke, output logic [4:0] res);
    logic [4:0] exp;
    exp = ref_rem(m, n);
    mode_aug = aug;
    for (int i = n - 1; i >= 0; i--) begin
      bit_vld = 1'b1; bit_in = m[i]; bit_last = (i == 0);
      @(negedge clk);
      bit_vld = 1'b0; bit_last = 1'b0;
      if (gap != 0 && i != 0 && (i % gap) == 0) begin
        bit_in = ~bit_in;
        @(negedge clk);
      end
    end
    if (aug) begin
      for (int j = 0; j < 5; j++) begin
        check(done == 1'b0, "R3 done early", done, 0);
        if (poke) begin bit_vld = 1'b1; bit_in = 1'b1; bit_last = 1'b1; end
        @(negedge clk);
      end
      bit_vld = 1'b0; bit_last = 1'b0;
    end
    check(done == 1'b1, aug ? "R3 done" : "R2 done", done, 1);
    check(crc_out == exp, aug ? (poke ? "R7 remainder" : "R3 remainder")
                              : (gap != 0 ? "R6 remainder" : "R2 remainder"),
          crc_out, exp);
    res = crc_out;
  endtask

  initial begin
    logic [4:0] r_dir, r_aug, held;
    rst_n = 1'b0; clr = 1'b0; mode_aug = 1'b0;
    bit_vld = 1'b0; bit_in = 1'b0; bit_last = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(crc_out == 5'd0 && done == 1'b0, "R1 reset", {done, crc_out}, 0);

    // table walk: every vector in both modes
    for (int v = 0; v < NV; v++) begin
      do_clear();
      send_msg(1'b0, V_MSG[v], V_LEN[v], 0, 1'b0, r_dir);
      do_clear();
      send_msg(1'b1, V_MSG[v], V_LEN[v], 0, 1'b0, r_aug);
      check(r_dir == r_aug, "R4 modes agree", r_aug, r_dir);
    end

    // R4 known stream in both modes
    do_clear(); send_msg(1'b0, 16'h0093, 8, 0, 1'b0, r_dir);
    check(r_dir == 5'b01010, "R4 direct 01010", r_dir, 5'b01010);
    do_clear(); send_msg(1'b1, 16'h0093, 8, 0, 1'b0, r_aug);
    check(r_aug == 5'b01010, "R4 division 01010", r_aug, 5'b01010);

    // R6 idle gaps inside messages
    do_clear(); send_msg(1'b0, 16'hA5C3, 16, 3, 1'b0, r_dir);
    do_clear(); send_msg(1'b1, 16'h0801, 12, 2, 1'b0, r_aug);

    // R7 inputs driven during flush
    do_clear(); send_msg(1'b1, 16'hFFFF, 16, 0, 1'b1, r_aug);
    do_clear(); send_msg(1'b1, 16'h0093, 8, 0, 1'b1, r_aug);

    // R8 bits after done are ignored
    held = r_aug;
    mode_aug = 1'b0;
    for (int k = 0; k < 4; k++) begin
      bit_vld = 1'b1; bit_in = k[0]; bit_last = k[1];
      @(negedge clk);
    end
    bit_vld = 1'b0; bit_last = 1'b0;
    check(crc_out == held && done == 1'b1, "R8 hold after done", crc_out, held);

    // R5 clear together with a valid bit mid-message
    do_clear();
    mode_aug = 1'b0;
    for (int k = 0; k < 3; k++) begin
      bit_vld = 1'b1; bit_in = 1'b1; bit_last = 1'b0;
      @(negedge clk);
    end
    check(crc_out != 5'd0, "R5 precondition", crc_out, 1);
    clr = 1'b1; bit_vld = 1'b1; bit_in = 1'b1;
    @(negedge clk);
    clr = 1'b0; bit_vld = 1'b0;
    check(crc_out == 5'd0 && done == 1'b0, "R5 clear wins", {done, crc_out}, 0);
    send_msg(1'b0, 16'h0010, 5, 0, 1'b0, r_dir);

    // R5 clear after done
    do_clear();
    check(crc_out == 5'd0 && done == 1'b0, "R5 clear after done", {done, crc_out}, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule